// File: doc/BRIEF.md
# Reset Qualifier and Machine-Cycle Generator

This block sits between the fast oscillator clock domain of a small 8-bit controller core and the core itself. It divides the oscillator clock into machine cycles of twelve clocks, each split into six states of two phases. It publishes the state and phase indices and a one-clock strobe at the final phase of every machine cycle.

It also screens the raw, asynchronous, active-high reset line. A pulse only counts as a reset once it has stayed high for two complete machine cycles. A qualified reset holds the core in reset for as long as the line stays high. It also starts a sequencer that writes zero to every location of the 128-byte internal RAM. The core leaves reset only when the line has dropped, a machine-cycle boundary has passed and the RAM clear has completed. The block also supplies the register values the core loads while in reset.

Top module: `mc_reset_ctrl`

## Requirements
- R1: `mc_strobe_o` is high for exactly one clock out of every 12, and the sequence repeats without gaps.
- R2: `state_o` counts 0,1,2,3,4,5 and `phase_o` alternates 0,1. `phase_o` changes every clock, `state_o` advances after each clock with `phase_o`=1, and `mc_strobe_o` is high exactly when `state_o`=5 and `phase_o`=1.
- R3: `rst_req_i` passes through a two-flop synchronizer. If it is sampled high on at least 24 consecutive rising edges (two machine cycles), `core_rst_o` goes high after the 26th edge counted from the first edge that sampled it high. A pulse of 23 edges or fewer leaves `core_rst_o` low.
- R4: A single sampled low on `rst_req_i` clears the accumulated high time. Two pulses of 20 edges separated by one low edge do not cause a reset.
- R5: `core_rst_o` stays high while `rst_req_i` stays high. Once the request has dropped and the RAM clear has completed, it falls only on a machine-cycle boundary: the first clock with `core_rst_o` low shows `state_o`=0 and `phase_o`=0. That happens no later than 14 edges after the request is removed.
- R6: The reset value outputs carry the program counter 0x0000, data pointer 0x0000, accumulator 0x00, B register 0x00, status word 0x00 and stack pointer 0x07.
- R7: Each qualified reset starts a clear burst on the edge that qualifies it. `ram_we_o` is high for exactly 128 consecutive clocks, with `ram_addr_o` stepping 0 to 127 in ascending order and `ram_wdata_o` equal to 0.
- R8: `core_rst_o` is high whenever `ram_we_o` is high. For a qualifying pulse of 24 to 30 edges, `core_rst_o` first falls after edge 154.
- R9: After `rst_n` is released, the block starts with `core_rst_o` high, a clear burst running from address 0, `state_o`=0 and `phase_o`=0. `core_rst_o` first reads low after the 128th edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low initialisation of the block's flops |
| rst_req_i | input | 1 | Raw asynchronous active-high reset request |
| mc_strobe_o | output | 1 | High on the last phase of every machine cycle |
| state_o | output | 3 | State index 0..5 within the machine cycle |
| phase_o | output | 1 | Phase index 0..1 within the state |
| core_rst_o | output | 1 | Qualified reset to the core, including RAM clear time |
| clr_busy_o | output | 1 | RAM clear sequencer running |
| ram_we_o | output | 1 | Internal RAM write enable from the clear sequencer |
| ram_addr_o | output | 7 | Internal RAM address during clear |
| ram_wdata_o | output | 8 | Internal RAM write data during clear (zero) |
| pc_init_o | output | 16 | Program counter reset value |
| dptr_init_o | output | 16 | Data pointer reset value |
| sp_init_o | output | 8 | Stack pointer reset value |
| psw_init_o | output | 8 | Status word reset value |
| acc_init_o | output | 8 | Accumulator reset value |
| b_init_o | output | 8 | B register reset value |

## Verification
A state or phase counter that steps wrongly shows up within one machine cycle as a state/phase pair out of sequence, or as a strobe that is not 12 clocks from the previous one. A high-time counter that does not clear or saturate appears as an off-by-one in the 26-edge reset latency, or as a false reset from split pulses. A wrong release condition appears on the first clock after reset falls, as a non-zero state or phase index. Clear sequencer faults appear within 128 clocks as a skipped address, a burst length other than 128, or a write while the core is out of reset.

// File: rtl/mcr_pkg.sv
// Package: shared widths and the core register reset values.
// Assumes an 8-bit core with 16-bit code and data pointers.
package mcr_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned PTR_W  = 16;

    localparam logic [PTR_W-1:0]  PC_RST   = 16'h0000;
    localparam logic [PTR_W-1:0]  DPTR_RST = 16'h0000;
    localparam logic [BYTE_W-1:0] SP_RST   = 8'h07;
    localparam logic [BYTE_W-1:0] PSW_RST  = 8'h00;
    localparam logic [BYTE_W-1:0] ACC_RST  = 8'h00;
    localparam logic [BYTE_W-1:0] B_RST    = 8'h00;
endpackage

// File: rtl/mcr_sync.sv
// Module: mcr_sync
// Multi-stage synchronizer for one asynchronous level into clk.
// Assumes the input is a slow level; STAGES >= 1.
module mcr_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // Capture the raw input in the first stage.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[0] <= 1'b0;
                else        chain[0] <= d_i;
            end
        end else begin : g_next
            // Shift the sample one stage further.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b0;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/mcr_timing.sv
// Module: mcr_timing
// Free-running machine-cycle generator: phase counter inside state counter,
// strobe on the final phase of the final state.
// Assumes N_STATES >= 2 and N_PHASES >= 2.
module mcr_timing #(
    parameter int unsigned N_STATES = 6,
    parameter int unsigned N_PHASES = 2,
    localparam int unsigned ST_W = $clog2(N_STATES),
    localparam int unsigned PH_W = $clog2(N_PHASES)
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [ST_W-1:0] state_o,
    output logic [PH_W-1:0] phase_o,
    output logic            strobe_o
);
    localparam logic [ST_W-1:0] ST_LAST = ST_W'(N_STATES - 1);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(N_PHASES - 1);

    logic [ST_W-1:0] state_q;
    logic [PH_W-1:0] phase_q;
    logic            ph_end;
    logic            st_end;

    assign ph_end = (phase_q == PH_LAST);
    assign st_end = (state_q == ST_LAST);

    // Step the phase every clock, wrapping after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n)      phase_q <= '0;
        else if (ph_end) phase_q <= '0;
        else             phase_q <= phase_q + PH_W'(1);
    end

    // Step the state when its last phase completes.
    always_ff @(posedge clk) begin
        if (!rst_n)      state_q <= '0;
        else if (ph_end) state_q <= st_end ? '0 : state_q + ST_W'(1);
    end

    assign strobe_o = ph_end && st_end;
    assign state_o  = state_q;
    assign phase_o  = phase_q;

    a_r2_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
        !ph_end |=> (phase_q == $past(phase_q) + PH_W'(1)) && $stable(state_q));
    a_r2_state_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_end && !st_end) |=> (state_q == $past(state_q) + ST_W'(1)) && (phase_q == '0));
    a_r1_cycle_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |=> (state_q == '0) && (phase_q == '0));
    a_r2_state_range: assert property (@(posedge clk) disable iff (!rst_n)
        state_q <= ST_LAST);
endmodule

// File: rtl/mcr_qualifier.sv
// Module: mcr_qualifier
// Measures how long the synchronized request has been high. Asserts the
// held reset once MIN_CLKS consecutive high samples are seen, and releases
// it at a cycle strobe after the request drops. Comes out of rst_n asserted.
// Assumes MIN_CLKS >= 2.
module mcr_qualifier #(
    parameter int unsigned MIN_CLKS = 24,
    localparam int unsigned CNT_W = $clog2(MIN_CLKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_s_i,
    input  logic strobe_i,
    output logic held_o,
    output logic qualify_o
);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(MIN_CLKS);
    localparam logic [CNT_W-1:0] CNT_HIT  = CNT_W'(MIN_CLKS - 1);

    logic [CNT_W-1:0] hi_cnt;
    logic             held_q;

    // Count consecutive high samples, saturating; any low sample clears.
    always_ff @(posedge clk) begin
        if (!rst_n)                 hi_cnt <= '0;
        else if (!req_s_i)          hi_cnt <= '0;
        else if (hi_cnt != CNT_MAX) hi_cnt <= hi_cnt + CNT_W'(1);
    end

    assign qualify_o = req_s_i && (hi_cnt == CNT_HIT);

    // Hold reset from qualification until a boundary with the request low.
    always_ff @(posedge clk) begin
        if (!rst_n)                     held_q <= 1'b1;
        else if (qualify_o)             held_q <= 1'b1;
        else if (!req_s_i && strobe_i)  held_q <= 1'b0;
    end

    assign held_o = held_q;

    a_r3_rise_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(held_q) |-> $past(req_s_i));
    a_r5_fall_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(held_q) |-> $past(strobe_i) && !$past(req_s_i));
    a_r5_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        (held_q && req_s_i) |=> held_q);
    a_r4_low_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        !req_s_i |=> !qualify_o);
endmodule

// File: rtl/mcr_ram_clear.sv
// Module: mcr_ram_clear
// Walks every internal RAM address in ascending order writing zero, one per
// clock, starting on a start pulse (restarting if already busy). Runs one
// full pass after rst_n. Assumes DEPTH >= 2.
module mcr_ram_clear #(
    parameter int unsigned DEPTH  = 128,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              busy_o,
    output logic              we_o,
    output logic [AW-1:0]     addr_o,
    output logic [DATA_W-1:0] wdata_o
);
    localparam logic [AW-1:0] ADDR_LAST = AW'(DEPTH - 1);

    logic          busy_q;
    logic [AW-1:0] addr_q;

    // Sequence the clear pass: restart on start, step while busy, stop at end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b1;
            addr_q <= '0;
        end else if (start_i) begin
            busy_q <= 1'b1;
            addr_q <= '0;
        end else if (busy_q) begin
            if (addr_q == ADDR_LAST) busy_q <= 1'b0;
            else                     addr_q <= addr_q + AW'(1);
        end
    end

    assign busy_o  = busy_q;
    assign we_o    = busy_q;
    assign addr_o  = addr_q;
    assign wdata_o = '0;

    a_r7_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !start_i && addr_q != ADDR_LAST) |=> busy_q && (addr_q == $past(addr_q) + AW'(1)));
    a_r7_end_at_last: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> $past(addr_q) == ADDR_LAST);
    a_r7_start_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_q && (addr_q == '0));
endmodule

// File: rtl/mc_reset_ctrl.sv
// Module: mc_reset_ctrl (top)
// Machine-cycle timing, reset qualification, RAM clear sequencing and core
// register reset values. Assumes rst_req_i is asynchronous to clk and that
// the core samples core_rst_o synchronously in the clk domain.
module mc_reset_ctrl #(
    parameter int unsigned N_STATES    = 6,
    parameter int unsigned N_PHASES    = 2,
    parameter int unsigned MIN_MC      = 2,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned RAM_DEPTH   = 128,
    localparam int unsigned ST_W = $clog2(N_STATES),
    localparam int unsigned PH_W = $clog2(N_PHASES),
    localparam int unsigned RA_W = $clog2(RAM_DEPTH),
    localparam int unsigned BW   = mcr_pkg::BYTE_W,
    localparam int unsigned PW   = mcr_pkg::PTR_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rst_req_i,
    output logic            mc_strobe_o,
    output logic [ST_W-1:0] state_o,
    output logic [PH_W-1:0] phase_o,
    output logic            core_rst_o,
    output logic            clr_busy_o,
    output logic            ram_we_o,
    output logic [RA_W-1:0] ram_addr_o,
    output logic [BW-1:0]   ram_wdata_o,
    output logic [PW-1:0]   pc_init_o,
    output logic [PW-1:0]   dptr_init_o,
    output logic [BW-1:0]   sp_init_o,
    output logic [BW-1:0]   psw_init_o,
    output logic [BW-1:0]   acc_init_o,
    output logic [BW-1:0]   b_init_o
);
    localparam int unsigned CLKS_PER_MC = N_STATES * N_PHASES;
    localparam int unsigned MIN_CLKS    = MIN_MC * CLKS_PER_MC;

    logic req_s;
    logic strobe;
    logic held;
    logic qualify;
    logic busy;

    mcr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (rst_req_i),
        .q_o   (req_s)
    );

    mcr_timing #(.N_STATES(N_STATES), .N_PHASES(N_PHASES)) u_timing (
        .clk      (clk),
        .rst_n    (rst_n),
        .state_o  (state_o),
        .phase_o  (phase_o),
        .strobe_o (strobe)
    );

    mcr_qualifier #(.MIN_CLKS(MIN_CLKS)) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_s_i   (req_s),
        .strobe_i  (strobe),
        .held_o    (held),
        .qualify_o (qualify)
    );

    mcr_ram_clear #(.DEPTH(RAM_DEPTH), .DATA_W(BW)) u_clear (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (qualify),
        .busy_o  (busy),
        .we_o    (ram_we_o),
        .addr_o  (ram_addr_o),
        .wdata_o (ram_wdata_o)
    );

    assign mc_strobe_o = strobe;
    assign clr_busy_o  = busy;
    assign core_rst_o  = held | busy;

    assign pc_init_o   = mcr_pkg::PC_RST;
    assign dptr_init_o = mcr_pkg::DPTR_RST;
    assign sp_init_o   = mcr_pkg::SP_RST;
    assign psw_init_o  = mcr_pkg::PSW_RST;
    assign acc_init_o  = mcr_pkg::ACC_RST;
    assign b_init_o    = mcr_pkg::B_RST;

    a_r8_start_enters_reset: assert property (@(posedge clk) disable iff (!rst_n)
        qualify |=> core_rst_o && ram_we_o);
    a_r5_release_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(core_rst_o) && !$past(busy)) |-> (state_o == '0) && (phase_o == '0));
endmodule

// File: tb/sim_mc_reset_ctrl.sv
// Bench: timing and RAM-clear monitors run every clock; reset pulses of
// every length up to 30 edges and long holds across all 12 release offsets.
module sim_mc_reset_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        rst_req_i;
    logic        mc_strobe_o;
    logic [2:0]  state_o;
    logic [0:0]  phase_o;
    logic        core_rst_o;
    logic        clr_busy_o;
    logic        ram_we_o;
    logic [6:0]  ram_addr_o;
    logic [7:0]  ram_wdata_o;
    logic [15:0] pc_init_o, dptr_init_o;
    logic [7:0]  sp_init_o, psw_init_o, acc_init_o, b_init_o;

    int checks = 0;
    int fails  = 0;
    int tb_cnt = 0;
    int exp_addr = 0;
    bit prev_we = 1'b0;
    bit any_rst = 1'b0;

    always #5 clk = ~clk;

    mc_reset_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .rst_req_i(rst_req_i),
        .mc_strobe_o(mc_strobe_o), .state_o(state_o), .phase_o(phase_o),
        .core_rst_o(core_rst_o), .clr_busy_o(clr_busy_o),
        .ram_we_o(ram_we_o), .ram_addr_o(ram_addr_o), .ram_wdata_o(ram_wdata_o),
        .pc_init_o(pc_init_o), .dptr_init_o(dptr_init_o), .sp_init_o(sp_init_o),
        .psw_init_o(psw_init_o), .acc_init_o(acc_init_o), .b_init_o(b_init_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Per-clock monitors: cycle position model (R1, R2) and clear burst (R7, R8).
    always @(negedge clk) begin
        if (!rst_n) begin
            tb_cnt  = 0;
            prev_we = 1'b0;
        end else begin
            chk(int'(state_o) == tb_cnt / 2, "R2", "state index", int'(state_o), tb_cnt / 2);
            chk(int'(phase_o) == tb_cnt % 2, "R2", "phase index", int'(phase_o), tb_cnt % 2);
            chk(mc_strobe_o == (tb_cnt == 11), "R1", "strobe position", int'(mc_strobe_o), int'(tb_cnt == 11));
            tb_cnt = (tb_cnt + 1) % 12;
            if (core_rst_o) any_rst = 1'b1;
            if (ram_we_o) begin
                if (!prev_we) exp_addr = 0;
                chk(int'(ram_addr_o) == exp_addr, "R7", "clear address", int'(ram_addr_o), exp_addr);
                chk(ram_wdata_o == 8'h00, "R7", "clear data", int'(ram_wdata_o), 0);
                chk(core_rst_o == 1'b1, "R8", "core reset during clear", int'(core_rst_o), 1);
                exp_addr++;
            end else if (prev_we) begin
                chk(exp_addr == 128, "R7", "burst length", exp_addr, 128);
            end
            prev_we = ram_we_o;
        end
    end

    // Pulse rst_req_i for h edges, then follow core_rst_o until it is released.
    task automatic run_pulse(input int h, output int seen, output int rel,
                             output int rel_st, output int rel_ph, output int gap);
        int n = 0;
        seen = 0; rel = 0; rel_st = -1; rel_ph = -1; gap = 0;
        @(posedge clk); #2;
        rst_req_i = 1'b1;
        while (n < h + 200 && rel == 0) begin
            @(posedge clk); n++;
            #2;
            if (n == h) rst_req_i = 1'b0;
            @(negedge clk);
            if (core_rst_o && seen == 0) seen = n;
            if (seen != 0 && n <= h + 2 && !core_rst_o) gap = 1;
            if (seen != 0 && rel == 0 && !core_rst_o) begin
                rel = n; rel_st = int'(state_o); rel_ph = int'(phase_o);
            end
        end
    endtask

    initial begin
        int seen, rel, rst_st, rst_ph, gap, n;
        rst_n = 1'b0;
        rst_req_i = 1'b0;
        repeat (5) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R9: state straight after initialisation
        chk(core_rst_o == 1'b1, "R9", "core reset at start", int'(core_rst_o), 1);
        chk(ram_we_o == 1'b1 && ram_addr_o == 7'd0, "R9", "clear starts at 0", int'(ram_addr_o), 0);
        chk(state_o == 3'd0 && phase_o == 1'b0, "R9", "timing at start", int'(state_o), 0);
        // R6: register reset values
        chk(pc_init_o == 16'h0000, "R6", "pc init", int'(pc_init_o), 0);
        chk(dptr_init_o == 16'h0000, "R6", "dptr init", int'(dptr_init_o), 0);
        chk(sp_init_o == 8'h07, "R6", "sp init", int'(sp_init_o), 7);
        chk(psw_init_o == 8'h00, "R6", "psw init", int'(psw_init_o), 0);
        chk(acc_init_o == 8'h00, "R6", "acc init", int'(acc_init_o), 0);
        chk(b_init_o == 8'h00, "R6", "b init", int'(b_init_o), 0);
        n = 0;
        while (core_rst_o && n < 400) begin
            @(negedge clk); n++;
        end
        chk(n == 128, "R9", "power-up release edge", n, 128);

        // R3 and R8: every pulse length from 1 to 30 edges
        for (int h = 1; h <= 30; h++) begin
            run_pulse(h, seen, rel, rst_st, rst_ph, gap);
            if (h < 24) begin
                chk(seen == 0, "R3", $sformatf("short pulse %0d ignored", h), seen, 0);
            end else begin
                chk(seen == 26, "R3", $sformatf("latency for pulse %0d", h), seen, 26);
                chk(rel == 154, "R8", $sformatf("release after clear, pulse %0d", h), rel, 154);
            end
        end

        // R4: two 20-edge pulses split by one low edge
        any_rst = 1'b0;
        @(posedge clk); #2 rst_req_i = 1'b1;
        repeat (20) @(posedge clk);
        #2 rst_req_i = 1'b0;
        @(posedge clk); #2 rst_req_i = 1'b1;
        repeat (20) @(posedge clk);
        #2 rst_req_i = 1'b0;
        repeat (40) @(posedge clk);
        @(negedge clk);
        chk(any_rst == 1'b0, "R4", "split pulses ignored", int'(any_rst), 0);

        // R5: long holds released at each of the 12 cycle offsets
        for (int h = 300; h < 312; h++) begin
            run_pulse(h, seen, rel, rst_st, rst_ph, gap);
            chk(seen == 26, "R3", $sformatf("latency for hold %0d", h), seen, 26);
            chk(gap == 0, "R5", $sformatf("held while high, hold %0d", h), gap, 0);
            chk(rel >= h + 3 && rel <= h + 14, "R5", $sformatf("release window, hold %0d", h), rel, h + 3);
            chk(rst_st == 0 && rst_ph == 0, "R5", $sformatf("release on boundary, hold %0d", h),
                rst_st * 2 + rst_ph, 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule